// File: doc/BRIEF.md
# Over-Current Circuit Breaker Controller

This block turns digitized over-current flags from a shunt-sense front end into shutdown and recovery control for the main power switch. Two comparator flags arrive each cycle. One says the sense voltage is above the nominal 50 mV breaker level. The other says it is above the selectable quick-trip level. A sustained excursion above the breaker level trips the breaker through a cycle-count filter. When current regulation is enabled, a separate, longer regulation window replaces that filter. A quick-trip excursion trips the breaker on the next clock edge.

After a trip the gate is held off and the active-low fault output is driven low. Recovery follows one of two modes. In automatic mode the breaker waits a cool-down period and then retries. In latched mode it waits for a qualified low pulse on the fault-clear input, followed by a restart delay. Each return to conduction produces a one-cycle restart request toward the start-up controller.

An optional permanent latch models a blown fuse. It survives both the fault-clear input and the block reset, and only a dedicated configuration write clears it. All timing parameters are expressed in clock cycles; the defaults assume a 1 MHz tick.

Top module: `oc_breaker`

## Requirements
- R1: After reset with no sticky fault, gate_off_o is 0, fault_no is 1, reg_active_o is 0 and restart_o is 0.
- R2: With reg_en_i low, over_lo_i sampled high on FILT_CYC consecutive rising edges while conducting trips the breaker at the last of those edges: gate_off_o goes 1 and fault_no goes 0.
- R3: over_lo_i sampled low on any edge before the trip edge clears the filter count, so a fresh run of FILT_CYC high samples is needed.
- R4: While conducting with qt_en_i high, over_qt_i sampled high trips the breaker at that same edge, whatever the filter or regulation count.
- R5: With qt_en_i low, over_qt_i has no effect on gate_off_o or fault_no.
- R6: With reg_en_i high, the window becomes REG_CYC consecutive high samples of over_lo_i. reg_active_o is 1 exactly while conducting with reg_en_i and over_lo_i high. A low sample before expiry aborts the window without a trip.
- R7: In automatic mode (auto_mode_i = 1), gate_off_o returns to 0 COOL_CYC edges after the trip edge. restart_o is 1 for exactly the first cycle of renewed conduction.
- R8: In latched mode (auto_mode_i = 0), the breaker stays off until clr_ni is sampled low on at least RST_MIN_CYC edges and then sampled high. fault_no returns to 1 at that release edge, and the gate turns on RESTART_CYC edges later with a restart_o pulse.
- R9: In latched mode, a clr_ni low pulse sampled on fewer than RST_MIN_CYC edges is ignored, and the breaker stays off with fault_no at 0.
- R10: A trip with nv_en_i high sets a sticky bit. While that bit is set, gate_off_o is 1 and fault_no is 0 regardless of clr_ni, auto_mode_i or rst_ni. Only nv_clr_i high at a clock edge clears the bit, after which normal recovery for the selected mode runs.
- R11: If over_lo_i is still high after a restart, the filter runs again from zero and the breaker trips again FILT_CYC edges into conduction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; does not clear the sticky bit |
| over_lo_i | input | 1 | Sense above the 50 mV breaker level |
| over_qt_i | input | 1 | Sense above the quick-trip level |
| qt_en_i | input | 1 | Quick-trip path enable (low = quick trip disabled) |
| auto_mode_i | input | 1 | 1 = automatic retry after cool-down, 0 = latched until cleared |
| clr_ni | input | 1 | Active-low fault clear for latched mode |
| reg_en_i | input | 1 | Current-regulation window enable |
| nv_en_i | input | 1 | Permanent (sticky) trip latch enable |
| nv_clr_i | input | 1 | Configuration write that clears the sticky bit |
| gate_off_o | output | 1 | 1 = switch gate held off |
| reg_active_o | output | 1 | Regulation window running |
| fault_no | output | 1 | Active-low fault indication |
| restart_o | output | 1 | One-cycle restart request to the start-up controller |

## Verification
The bench builds the breaker with FILT_CYC=4, REG_CYC=10, COOL_CYC=20, RST_MIN_CYC=3 and RESTART_CYC=6. These values shrink the 2.5 s cool-down and the pin-detect restart delay to a few dozen cycles. That lets the bench cover filter abort and expiry, regulation abort, re-trip after an automatic retry, a short and a qualified latched clear, and a power cycle with the sticky bit set, all in one short run. The 3-cycle minimum clear pulse makes the rejection of a 2-cycle pulse observable, which the default of 1 cycle could not show.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_COOL  = 3'd1,
    ST_ARM   = 3'd2,
    ST_LOWP  = 3'd3,
    ST_DELAY = 3'd4,
    ST_LOCK  = 3'd5
  } brk_state_e;
endpackage

// File: rtl/oc_trip_filter.sv
module oc_trip_filter #(
  parameter int FILT_CYC = 50,
  parameter int REG_CYC  = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic over_lo_i,
  input  logic over_qt_i,
  input  logic qt_en_i,
  input  logic reg_en_i,
  output logic trip_o,
  output logic reg_active_o
);
  localparam int FMAX = (FILT_CYC > REG_CYC) ? FILT_CYC : REG_CYC;
  localparam int FCW  = $clog2(FMAX + 1);
  localparam logic [FCW-1:0] FILT_LAST = FCW'(FILT_CYC - 1);
  localparam logic [FCW-1:0] REG_LAST  = FCW'(REG_CYC - 1);

  logic [FCW-1:0] fcnt_q, fcnt_d, last;
  logic           hit, quick;

  assign last  = reg_en_i ? REG_LAST : FILT_LAST;
  assign hit   = (fcnt_q >= last);
  assign quick = qt_en_i & over_qt_i;

  always_comb begin
    if (!armed_i || !over_lo_i || hit) fcnt_d = '0;
    else                               fcnt_d = fcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fcnt_q <= '0;
    else         fcnt_q <= fcnt_d;
  end

  assign trip_o       = armed_i & (quick | (over_lo_i & hit));
  assign reg_active_o = armed_i & reg_en_i & over_lo_i;

  // R3: a low sample always restarts the window
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !over_lo_i |=> (fcnt_q == '0));
endmodule

// File: rtl/oc_sticky.sv
module oc_sticky (
  input  logic clk_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // no reset: models a fuse that survives power cycling
  logic q;
  always_ff @(posedge clk_i) begin
    if (clr_i)      q <= 1'b0;
    else if (set_i) q <= 1'b1;
  end
  assign q_o = q;
endmodule

// File: rtl/oc_recovery.sv
module oc_recovery
  import oc_pkg::*;
#(
  parameter int COOL_CYC    = 2500000,
  parameter int RST_MIN_CYC = 1,
  parameter int RESTART_CYC = 80000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic sticky_i,
  input  logic lock_i,
  input  logic auto_i,
  input  logic clr_ni,
  output logic run_o,
  output logic fault_o,
  output logic restart_o
);
  localparam int CM1  = (COOL_CYC > RESTART_CYC) ? COOL_CYC : RESTART_CYC;
  localparam int CMAX = (CM1 > RST_MIN_CYC) ? CM1 : RST_MIN_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] COOL_LAST    = CW'(COOL_CYC - 1);
  localparam logic [CW-1:0] RESTART_LAST = CW'(RESTART_CYC - 1);
  localparam logic [CW-1:0] RST_MIN_L    = CW'(RST_MIN_CYC);
  localparam logic [CW-1:0] ONE          = CW'(1);

  brk_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           restart_q, restart_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    restart_d = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (sticky_i) state_d = ST_LOCK;
        else if (trip_i) begin
          cnt_d = '0;
          if (lock_i)      state_d = ST_LOCK;
          else if (auto_i) state_d = ST_COOL;
          else             state_d = ST_ARM;
        end
      end
      ST_COOL: begin
        if (cnt_q == COOL_LAST) begin
          state_d   = ST_RUN;
          restart_d = 1'b1;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_ARM: begin
        if (!clr_ni) begin
          state_d = ST_LOWP;
          cnt_d   = ONE;
        end
      end
      ST_LOWP: begin
        if (!clr_ni) begin
          if (cnt_q < RST_MIN_L) cnt_d = cnt_q + 1'b1;
        end else if (cnt_q >= RST_MIN_L) begin
          state_d = ST_DELAY;
          cnt_d   = '0;
        end else state_d = ST_ARM;
      end
      ST_DELAY: begin
        if (!clr_ni) begin
          state_d = ST_LOWP;
          cnt_d   = ONE;
        end else if (cnt_q == RESTART_LAST) begin
          state_d   = ST_RUN;
          restart_d = 1'b1;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_LOCK: begin
        if (!sticky_i) begin
          cnt_d   = '0;
          state_d = auto_i ? ST_COOL : ST_ARM;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      cnt_q     <= '0;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      restart_q <= restart_d;
    end
  end

  assign run_o     = (state_q == ST_RUN);
  assign fault_o   = (state_q == ST_COOL) | (state_q == ST_ARM) |
                     (state_q == ST_LOWP) | (state_q == ST_LOCK);
  assign restart_o = restart_q;

  // R7: restart request only while conducting, one cycle wide
  p_restart_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> run_o);
  p_restart_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o);
  // R8: latched breaker stays off without a clear pulse
  p_latched_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARM && clr_ni) |=> !run_o);
endmodule

// File: rtl/oc_breaker.sv
module oc_breaker #(
  parameter int FILT_CYC    = 50,
  parameter int REG_CYC     = 1000,
  parameter int COOL_CYC    = 2500000,
  parameter int RST_MIN_CYC = 1,
  parameter int RESTART_CYC = 80000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic over_lo_i,
  input  logic over_qt_i,
  input  logic qt_en_i,
  input  logic auto_mode_i,
  input  logic clr_ni,
  input  logic reg_en_i,
  input  logic nv_en_i,
  input  logic nv_clr_i,
  output logic gate_off_o,
  output logic reg_active_o,
  output logic fault_no,
  output logic restart_o
);
  logic run, fault, trip, sticky_q, armed;

  assign armed = run & ~sticky_q;

  oc_trip_filter #(.FILT_CYC(FILT_CYC), .REG_CYC(REG_CYC)) u_filter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .armed_i      (armed),
    .over_lo_i    (over_lo_i),
    .over_qt_i    (over_qt_i),
    .qt_en_i      (qt_en_i),
    .reg_en_i     (reg_en_i),
    .trip_o       (trip),
    .reg_active_o (reg_active_o)
  );

  oc_sticky u_sticky (
    .clk_i (clk_i),
    .set_i (trip & nv_en_i),
    .clr_i (nv_clr_i),
    .q_o   (sticky_q)
  );

  oc_recovery #(
    .COOL_CYC    (COOL_CYC),
    .RST_MIN_CYC (RST_MIN_CYC),
    .RESTART_CYC (RESTART_CYC)
  ) u_recovery (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trip_i    (trip),
    .sticky_i  (sticky_q),
    .lock_i    (nv_en_i),
    .auto_i    (auto_mode_i),
    .clr_ni    (clr_ni),
    .run_o     (run),
    .fault_o   (fault),
    .restart_o (restart_o)
  );

  assign gate_off_o = ~run | sticky_q;
  assign fault_no   = ~(fault | sticky_q);

  // R4: quick trip acts at the next edge
  p_quick_trip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_off_o && qt_en_i && over_qt_i) |=> gate_off_o);
  // R10: sticky bit forces the fault and holds until written
  p_sticky_fault_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_q |-> (!fault_no && gate_off_o));
  p_sticky_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_q && !nv_clr_i) |=> sticky_q);
endmodule

// File: tb/oc_breaker_bench.sv
module oc_breaker_bench;
  localparam int CLK_NS  = 10;
  localparam int FILT    = 4;
  localparam int REGW    = 10;
  localparam int COOL    = 20;
  localparam int RSTMIN  = 3;
  localparam int RESTART = 6;

  logic clk = 1'b0;
  logic rst_n, over_lo, over_qt, qt_en, auto_mode, clr_n, reg_en, nv_en, nv_clr;
  logic gate_off, reg_act, fault_n, restart;

  oc_breaker #(
    .FILT_CYC(FILT), .REG_CYC(REGW), .COOL_CYC(COOL),
    .RST_MIN_CYC(RSTMIN), .RESTART_CYC(RESTART)
  ) u_oc_breaker (
    .clk_i(clk), .rst_ni(rst_n), .over_lo_i(over_lo), .over_qt_i(over_qt),
    .qt_en_i(qt_en), .auto_mode_i(auto_mode), .clr_ni(clr_n), .reg_en_i(reg_en),
    .nv_en_i(nv_en), .nv_clr_i(nv_clr), .gate_off_o(gate_off),
    .reg_active_o(reg_act), .fault_no(fault_n), .restart_o(restart)
  );

  always #(CLK_NS/2) clk = ~clk;

  typedef struct {
    int    cyc;
    logic  g, f, r, s;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, n_chk = 0, n_err = 0;
  bit done = 0;

  always @(posedge clk) cyc++;

  // monitor: compare queued expectations a quarter period after each edge
  initial forever begin
    @(posedge clk);
    #(CLK_NS/4);
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (gate_off !== e.g || fault_n !== e.f || reg_act !== e.r || restart !== e.s) begin
        n_err++;
        $display("FAIL %s @%0d: got gate_off=%b fault_n=%b reg_act=%b restart=%b exp %b %b %b %b",
                 e.tag, cyc, gate_off, fault_n, reg_act, restart, e.g, e.f, e.r, e.s);
      end
    end
  end

  task automatic expect_at(int dly, logic g, logic f, logic r, logic s, string tag);
    exp_t e;
    e.cyc = cyc + dly; e.g = g; e.f = f; e.r = r; e.s = s; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      n_err += q.size();
      n_chk += q.size();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 20000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 0; over_lo = 0; over_qt = 0; qt_en = 1; auto_mode = 1;
    clr_n = 1; reg_en = 0; nv_en = 0; nv_clr = 1;
    step(3);
    rst_n = 1; nv_clr = 0;
    expect_at(1, 0, 1, 0, 0, "R1 reset state");
    step(2);

    // R3: interrupted run does not trip, R2: full run trips
    over_lo = 1;
    expect_at(3, 0, 1, 0, 0, "R3 three samples no trip");
    step(3);
    over_lo = 0;
    step(1);
    over_lo = 1;
    expect_at(3, 0, 1, 0, 0, "R3 count restarted");
    expect_at(4, 1, 0, 0, 0, "R2 filtered trip");
    step(4);

    // R7 auto retry, R11 re-trip with over-current still present
    expect_at(19, 1, 0, 0, 0, "R7 still cooling");
    expect_at(20, 0, 1, 0, 1, "R7 retry with restart pulse");
    expect_at(23, 0, 1, 0, 0, "R11 conducting before re-trip");
    expect_at(24, 1, 0, 0, 0, "R11 re-trip");
    step(24);
    over_lo = 0;
    expect_at(20, 0, 1, 0, 1, "R7 second retry");
    expect_at(21, 0, 1, 0, 0, "R7 restart one cycle");
    step(21);

    // R4 quick trip
    over_lo = 1; over_qt = 1;
    expect_at(1, 1, 0, 0, 0, "R4 quick trip");
    step(1);
    over_lo = 0; over_qt = 0;
    expect_at(20, 0, 1, 0, 1, "R7 retry after quick trip");
    step(21);

    // R5 quick trip disabled
    qt_en = 0; over_qt = 1;
    expect_at(6, 0, 1, 0, 0, "R5 quick trip ignored");
    step(6);
    over_qt = 0; qt_en = 1;

    // R6 regulation window with abort
    reg_en = 1; over_lo = 1;
    expect_at(1, 0, 1, 1, 0, "R6 regulation active");
    expect_at(8, 0, 1, 1, 0, "R6 past filter length no trip");
    step(8);
    over_lo = 0;
    expect_at(1, 0, 1, 0, 0, "R6 abort clears flag");
    step(1);
    over_lo = 1;
    expect_at(9, 0, 1, 1, 0, "R6 window running");
    expect_at(10, 1, 0, 0, 0, "R6 regulation timeout trip");
    step(10);
    over_lo = 0;
    expect_at(20, 0, 1, 0, 1, "R7 retry after regulation trip");
    step(21);

    // R4 bypasses the regulation window
    over_lo = 1;
    step(2);
    over_qt = 1;
    expect_at(1, 1, 0, 0, 0, "R4 quick trip during regulation");
    step(1);
    over_lo = 0; over_qt = 0; reg_en = 0;
    expect_at(20, 0, 1, 0, 1, "R7 retry after bypass");
    step(21);

    // R8/R9 latched mode
    auto_mode = 0; over_lo = 1; over_qt = 1;
    step(1);
    over_lo = 0; over_qt = 0;
    expect_at(25, 1, 0, 0, 0, "R8 latched stays off");
    step(25);
    clr_n = 0;
    step(2);
    clr_n = 1;
    expect_at(8, 1, 0, 0, 0, "R9 short clear ignored");
    step(8);
    clr_n = 0;
    expect_at(3, 1, 0, 0, 0, "R8 fault held during clear");
    step(3);
    clr_n = 1;
    expect_at(1, 1, 1, 0, 0, "R8 fault released");
    expect_at(6, 1, 1, 0, 0, "R8 restart delay");
    expect_at(7, 0, 1, 0, 1, "R8 gate restarted");
    expect_at(8, 0, 1, 0, 0, "R8 restart pulse ends");
    step(8);

    // R10 sticky latch
    auto_mode = 1; nv_en = 1; over_qt = 1; over_lo = 1;
    step(1);
    over_qt = 0; over_lo = 0; nv_en = 0;
    expect_at(30, 1, 0, 0, 0, "R10 no auto retry");
    step(30);
    auto_mode = 0; clr_n = 0;
    step(4);
    clr_n = 1;
    expect_at(10, 1, 0, 0, 0, "R10 clear input ignored");
    step(10);
    auto_mode = 1;
    rst_n = 0;
    step(2);
    rst_n = 1;
    expect_at(1, 1, 0, 0, 0, "R10 survives reset");
    expect_at(25, 1, 0, 0, 0, "R10 held after reset");
    step(25);
    nv_clr = 1;
    step(1);
    nv_clr = 0;
    expect_at(20, 1, 0, 0, 0, "R10 cooling after config write");
    expect_at(21, 0, 1, 0, 1, "R10 recovered after config write");
    step(23);

    finish_run();
  end
endmodule